// File: doc/BRIEF.md
# Prioritized Bus Error Status Capture

This block sits beside a bus interface node and gathers the error events that the node's checkers raise. Every error type owns one sticky flag bit, so software can see every kind of fault that happened since the last clear. In addition, a single diagnostic snapshot holds the error code, address, syndrome and command of the one error judged most important. Errors are ranked on five priority levels. A faulty write that was corrected outranks a faulty read that was corrected, because the stored data stays damaged after the write.

The snapshot is loaded when it is empty. It is replaced only by an error of strictly higher priority, so among errors of equal rank the first one is kept. Errors that arrive together in one cycle are resolved by level first and then by bit position. Software clears flags with a write-one-to-clear mask. Clearing the last set flag empties the snapshot, so the next error of any rank is captured. An interrupt line reflects any set flag, and a second line reflects any set flag on the two uncorrectable levels.

Top module: `errcap_top`

## Requirements
- R1: Flag bit i (0..8) is set on the cycle after errStrobe[i] is high and then stays set. Flag bit 9 is set only when busDataErr and inTransfer are both high, and busDataErr alone changes nothing.
- R2: Priority levels, with 1 the highest: bits 0..3 (fatal no-acknowledge, address parity, address transmit check, bad address) are level 1; bits 4 (uncorrectable data) and 5 (no-acknowledge) are level 2; bit 6 (corrected write data) is level 3; bit 7 (corrected read data) is level 4; bits 8 (node-specific) and 9 (bus data error during a transfer) are level 5.
- R3: When clrWe is high, each flag whose clrMask bit is 1 is cleared. If an error of that type arrives in the same cycle, the flag stays set.
- R4: When capLevel is 0 (snapshot empty), any error is captured: capCode takes its bit index, capLevel takes its level, and capAddr, capSyn and capCmd take the payload of that cycle.
- R5: A valid snapshot is overwritten only by an error whose level number is strictly smaller. An error of equal or lower priority leaves capCode, capLevel and the payload unchanged.
- R6: Among errors that arrive in the same cycle, the one with the smallest level number wins, and within that level the one with the lowest bit index wins.
- R7: A clear that leaves no flag set invalidates the snapshot: capLevel, capCode, capAddr, capSyn and capCmd become 0. If an error arrives in that same cycle, it is captured instead.
- R8: irq is high while any flag is set. irqSevere is high while any of flag bits 0..5 is set.
- R9: While rstN is low, all flags and snapshot fields are 0. All outputs are registered and change on the clock edge that samples their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errStrobe | input | 9 | Per-cycle error strobes for flag bits 0..8 |
| busDataErr | input | 1 | Bus data-error indication |
| inTransfer | input | 1 | Node takes part in the current transfer, as commander or as slave |
| errAddr | input | ADDR_W | Address payload of this cycle's error |
| errSyn | input | SYN_W | Syndrome payload of this cycle's error |
| errCmd | input | CMD_W | Command payload of this cycle's error |
| clrWe | input | 1 | Software clear strobe |
| clrMask | input | 10 | Write-one-to-clear mask for the flag bits |
| errFlags | output | 10 | Sticky error flags |
| capCode | output | 4 | Bit index of the captured error |
| capLevel | output | 3 | Level of the captured error, 0 when the snapshot is empty |
| capAddr | output | ADDR_W | Captured address |
| capSyn | output | SYN_W | Captured syndrome |
| capCmd | output | CMD_W | Captured command |
| irq | output | 1 | Any flag set |
| irqSevere | output | 1 | Any level 1 or level 2 flag set |

## Verification
The assertions assume that the payload inputs describe whatever error is strobed in the same cycle. They also assume that the clear mask is only meaningful while clrWe is high, and that the inputs are stable around the clock edge. The stimulus changes every input one time unit after a rising edge. It drives the payload on every cycle, including cycles with no strobe, so that a wrong capture shows up as a payload mismatch. Random phases mix strobes and clears with low density, so that ties, same-cycle clears and overwrites by higher priority all occur within the legal input space.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int NUM_ERR = 10;
  localparam int NUM_SRC = NUM_ERR - 1;
  localparam int CODE_W  = $clog2(NUM_ERR);
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 5;
  localparam int SEVERE_MAX_LVL = 2;

  typedef logic [LVL_W-1:0]   level_t;
  typedef logic [NUM_ERR-1:0] errVec_t;

  // Rank of each flag bit; 1 is the most important.
  function automatic level_t levelOf(input int idx);
    if (idx <= 3)      return level_t'(1);
    else if (idx <= 5) return level_t'(2);
    else if (idx == 6) return level_t'(3);
    else if (idx == 7) return level_t'(4);
    else               return level_t'(5);
  endfunction

  function automatic errVec_t levelMask(input int lvl);
    errVec_t m;
    m = '0;
    for (int i = 0; i < NUM_ERR; i++)
      if (int'(levelOf(i)) == lvl) m[i] = 1'b1;
    return m;
  endfunction

  function automatic errVec_t severeMask();
    errVec_t m;
    m = '0;
    for (int i = 0; i < NUM_ERR; i++)
      if (int'(levelOf(i)) <= SEVERE_MAX_LVL) m[i] = 1'b1;
    return m;
  endfunction

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    errVec_t             events;
    errVec_t             clrBits;
    logic                capture;
    logic                clearAll;
    logic [CODE_W-1:0]   winCode;
    level_t              winLevel;
  } ctrlStrobes_t;
endpackage

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errStrobe,
  input  logic               busDataErr,
  input  logic               inTransfer,
  input  logic               clrWe,
  input  errVec_t            clrMask,
  input  errVec_t            flags,
  input  level_t             capLevel,
  output ctrlStrobes_t       strb
);
  errVec_t           events;
  errVec_t           clrBits;
  errVec_t           remaining;
  errVec_t           cand;
  errVec_t           lvlMask [1:NUM_LVL];
  logic [NUM_LVL:1]  lvlHit;
  level_t            bestLevel;
  level_t            effLevel;
  logic [CODE_W-1:0] winCode;
  logic              clearAll;
  logic              capture;

  assign events    = {busDataErr & inTransfer, errStrobe};
  assign clrBits   = clrWe ? clrMask : '0;
  assign remaining = flags & ~clrBits;
  assign clearAll  = clrWe && (remaining == '0);
  assign effLevel  = clearAll ? '0 : capLevel;

  for (genvar g = 1; g <= NUM_LVL; g++) begin : gLvl
    assign lvlMask[g] = levelMask(g);
    assign lvlHit[g]  = |(events & lvlMask[g]);
  end

  always_comb begin
    bestLevel = '0;
    for (int l = NUM_LVL; l >= 1; l--)
      if (lvlHit[l]) bestLevel = level_t'(l);
  end

  always_comb begin
    cand = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (bestLevel == level_t'(l)) cand = events & lvlMask[l];
  end

  always_comb begin
    winCode = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--)
      if (cand[i]) winCode = CODE_W'(i);
  end

  assign capture = (bestLevel != '0) &&
                   ((effLevel == '0) || (bestLevel < effLevel));

  always_comb begin
    strb          = '0;
    strb.events   = events;
    strb.clrBits  = clrBits;
    strb.capture  = capture;
    strb.clearAll = clearAll;
    strb.winCode  = winCode;
    strb.winLevel = bestLevel;
  end

  // R4: an empty snapshot must take any arriving error
  a_r4_empty_takes_any: assert property (@(posedge clk) disable iff (!rstN)
    (capLevel == '0 && events != '0) |-> strb.capture);

  // R1: a bus data error outside a transfer raises no event
  a_r1_gate_transfer: assert property (@(posedge clk) disable iff (!rstN)
    (!inTransfer && errStrobe == '0) |-> !strb.capture);
endmodule

// File: rtl/errcap_data.sv
module errcap_data
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic [CMD_W-1:0]  errCmd,
  output errVec_t           errFlags,
  output logic [CODE_W-1:0] capCode,
  output level_t            capLevel,
  output logic [ADDR_W-1:0] capAddr,
  output logic [SYN_W-1:0]  capSyn,
  output logic [CMD_W-1:0]  capCmd,
  output logic              irq,
  output logic              irqSevere
);
  localparam errVec_t SEV_MASK = severeMask();

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (errFlags & ~strb.clrBits) | strb.events;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCode  <= '0;
      capLevel <= '0;
      capAddr  <= '0;
      capSyn   <= '0;
      capCmd   <= '0;
    end else if (strb.capture) begin
      capCode  <= strb.winCode;
      capLevel <= strb.winLevel;
      capAddr  <= errAddr;
      capSyn   <= errSyn;
      capCmd   <= errCmd;
    end else if (strb.clearAll) begin
      capCode  <= '0;
      capLevel <= '0;
      capAddr  <= '0;
      capSyn   <= '0;
      capCmd   <= '0;
    end
  end

  assign irq       = |errFlags;
  assign irqSevere = |(errFlags & SEV_MASK);

  // R1: without a clear no flag ever drops
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBits == '0) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R5: a valid snapshot never moves to a lower priority
  a_r5_no_downgrade: assert property (@(posedge clk) disable iff (!rstN)
    (capLevel != '0 && !strb.clearAll) |=> (capLevel != '0 && capLevel <= $past(capLevel)));

  // R7: a clear that empties the flags with no new error empties the snapshot
  a_r7_invalidate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && !strb.capture) |=> (capLevel == '0 && errFlags == '0));
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int CMD_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errStrobe,
  input  logic               busDataErr,
  input  logic               inTransfer,
  input  logic [ADDR_W-1:0]  errAddr,
  input  logic [SYN_W-1:0]   errSyn,
  input  logic [CMD_W-1:0]   errCmd,
  input  logic               clrWe,
  input  logic [NUM_ERR-1:0] clrMask,
  output logic [NUM_ERR-1:0] errFlags,
  output logic [CODE_W-1:0]  capCode,
  output logic [LVL_W-1:0]   capLevel,
  output logic [ADDR_W-1:0]  capAddr,
  output logic [SYN_W-1:0]   capSyn,
  output logic [CMD_W-1:0]   capCmd,
  output logic               irq,
  output logic               irqSevere
);
  ctrlStrobes_t strb;

  errcap_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .errStrobe  (errStrobe),
    .busDataErr (busDataErr),
    .inTransfer (inTransfer),
    .clrWe      (clrWe),
    .clrMask    (clrMask),
    .flags      (errFlags),
    .capLevel   (capLevel),
    .strb       (strb)
  );

  errcap_data #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .CMD_W(CMD_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .errAddr   (errAddr),
    .errSyn    (errSyn),
    .errCmd    (errCmd),
    .errFlags  (errFlags),
    .capCode   (capCode),
    .capLevel  (capLevel),
    .capAddr   (capAddr),
    .capSyn    (capSyn),
    .capCmd    (capCmd),
    .irq       (irq),
    .irqSevere (irqSevere)
  );

  // R8: a held snapshot always comes with a raised interrupt
  a_r8_irq_with_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    (capLevel != '0) |-> irq);
endmodule

// File: tb/tb_errcap_top.sv
module tb_errcap_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  errStrobe = '0;
  logic        busDataErr = 1'b0;
  logic        inTransfer = 1'b0;
  logic [31:0] errAddr = '0;
  logic [7:0]  errSyn = '0;
  logic [3:0]  errCmd = '0;
  logic        clrWe = 1'b0;
  logic [9:0]  clrMask = '0;
  logic [9:0]  errFlags;
  logic [3:0]  capCode;
  logic [2:0]  capLevel;
  logic [31:0] capAddr;
  logic [7:0]  capSyn;
  logic [3:0]  capCmd;
  logic        irq, irqSevere;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit [9:0]  mFlags = '0;
  int        mLevel = 0, mCode = 0;
  bit [31:0] mAddr = '0;
  bit [7:0]  mSyn = '0;
  bit [3:0]  mCmd = '0;

  errcap_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lvOf(int i);
    case (i)
      0, 1, 2, 3: return 1;
      4, 5:       return 2;
      6:          return 3;
      7:          return 4;
      default:    return 5;
    endcase
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit [9:0] ev, clr, rem;
    bit clearAll, found;
    int eff, wl, wc;
    ev = {busDataErr & inTransfer, errStrobe};
    clr = clrWe ? clrMask : '0;
    rem = mFlags & ~clr;
    clearAll = clrWe && (rem == 0);
    eff = clearAll ? 0 : mLevel;
    found = 0; wl = 0; wc = 0;
    for (int lv = 1; lv <= 5; lv++)
      for (int i = 0; i < NE; i++)
        if (!found && ev[i] && lvOf(i) == lv) begin found = 1; wl = lv; wc = i; end
    @(posedge clk); #1;
    if (found && (eff == 0 || wl < eff)) begin
      mLevel = wl; mCode = wc; mAddr = errAddr; mSyn = errSyn; mCmd = errCmd;
    end else if (clearAll) begin
      mLevel = 0; mCode = 0; mAddr = 0; mSyn = 0; mCmd = 0;
    end
    mFlags = rem | ev;
    chk("R1", "errFlags", errFlags, mFlags);
    chk("R5", "capLevel", capLevel, mLevel);
    chk("R5", "capCode", capCode, mCode);
    chk("R4", "capAddr", capAddr, mAddr);
    chk("R4", "capSyn", capSyn, mSyn);
    chk("R4", "capCmd", capCmd, mCmd);
    chk("R8", "irq", irq, |mFlags);
    chk("R8", "irqSevere", irqSevere, |mFlags[5:0]);
    errStrobe = '0; busDataErr = 0; inTransfer = 0; clrWe = 0; clrMask = '0;
  endtask

  task automatic errIn(bit [9:0] v, bit [31:0] a);
    errStrobe = v[8:0]; busDataErr = v[9]; inTransfer = v[9];
    errAddr = a; errSyn = a[7:0] ^ 8'h5A; errCmd = a[3:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "flags in reset", errFlags, 0);
    chk("R9", "level in reset", capLevel, 0);
    chk("R9", "irq in reset", irq, 0);
    rstN = 1'b1;
    step();

    // R4: first error into empty snapshot (corrected read, level 4)
    errIn(10'h080, 32'h1000_0007); step();
    chk("R2", "corrected read level", capLevel, 4);
    // R5: corrected write outranks corrected read
    errIn(10'h040, 32'h2000_0006); step();
    chk("R2", "corrected write level", capLevel, 3);
    // R5: equal priority keeps the first
    errIn(10'h040, 32'h3000_0006); step();
    chk("R5", "first of equal kept", capAddr, 32'h2000_0006);
    // R5: lower priority ignored
    errIn(10'h100, 32'h4000_0008); step();
    chk("R5", "lower ignored", capCode, 6);
    // uncorrectable, level 2
    errIn(10'h010, 32'h5000_0004); step();
    chk("R8", "severe raised", irqSevere, 1);
    // R6: simultaneous bits 0, 3, 8
    errIn(10'h109, 32'h6000_0000); step();
    chk("R6", "simultaneous winner", capCode, 0);
    // R3: partial clear keeps snapshot
    clrWe = 1; clrMask = 10'h001; step();
    chk("R3", "bit0 cleared", errFlags[0], 0);
    chk("R7", "snapshot kept on partial clear", capLevel, 1);
    // R7: clear all
    clrWe = 1; clrMask = 10'h3FF; errAddr = 32'hDEAD_BEEF; step();
    chk("R7", "snapshot empty", capLevel, 0);
    chk("R7", "payload zero", capAddr, 0);
    // R1: bus data error outside a transfer is ignored
    busDataErr = 1; inTransfer = 0; step();
    chk("R1", "no flag outside transfer", errFlags, 0);
    errIn(10'h200, 32'h7000_0009); step();
    chk("R2", "bus data error level", capLevel, 5);
    // R3: clear and new error of same type together, flag stays
    errIn(10'h200, 32'h8000_0009); clrWe = 1; clrMask = 10'h200; step();
    chk("R3", "same-cycle arrival wins", errFlags[9], 1);
    chk("R7", "recaptured after empty", capAddr, 32'h8000_0009);
    // R6: tie within level 2
    clrWe = 1; clrMask = 10'h3FF; step();
    errIn(10'h030, 32'h9000_0005); step();
    chk("R6", "lowest bit in level", capCode, 4);

    // random phase compared every cycle
    for (int n = 0; n < 3000; n++) begin
      bit [9:0] v;
      v = '0;
      for (int i = 0; i < NE; i++) v[i] = ($urandom_range(0, 15) == 0);
      errStrobe = v[8:0];
      busDataErr = v[9];
      inTransfer = $urandom_range(0, 1);
      errAddr = $urandom; errSyn = $urandom; errCmd = $urandom;
      clrWe = ($urandom_range(0, 9) == 0);
      clrMask = ($urandom_range(0, 2) == 0) ? 10'h3FF : 10'($urandom);
      step();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule